// File: doc/BRIEF.md
# Stereo Input Sample Store with Gain Scaling

This block takes a left/right pair of signed input samples, one pair per input-rate strobe, and scales both by a common gain. It then writes them into a pair of circular sample memories, one for each channel. The gain is the product of two factors.

- The first is a rate attenuation: when the converter decimates, the input is multiplied by the output-to-input rate ratio. This stops the longer convolution downstream from overflowing.
- The second is a mute gain that ramps linearly down to silence when muting is requested and back up when it is released. This gives click-free muting.

Each accepted pair advances a write counter. The write location is that counter plus a fixed guard distance, modulo the memory depth. The guard keeps the convolution engine's read pointer clear of the location being written. The convolution engine reads both channels at any address through a registered read port.

The mute ramp is a four-state machine. Its states and transitions are all taken only on an accepted strobe:

- OPEN (gain 1.0) moves to FADE_OUT when mute is requested.
- FADE_OUT steps the level down once per sample. It goes to SILENT when the level reaches zero, or turns to FADE_IN if the request is dropped. It jumps to OPEN if the request is dropped one step below full.
- SILENT (gain 0) goes to FADE_IN when the request is released.
- FADE_IN steps the level up once per sample. It goes to OPEN at full level, or turns back to FADE_OUT on a new request. It jumps to SILENT if the request returns at level one.

Top module: `stereo_gain_fifo`

## Requirements
- R1: After reset both read outputs are 0, the mute level is full (gain 1.0, state OPEN) and the write counter is 0.
- R2: The k-th accepted pair (k counted from 0 after reset) is written at address (k + 16) mod 512 in both channel memories, so the first pair lands at address 16.
- R3: Read data for an address presented on `rd_addr` appears on `rd_left`/`rd_right` after the next rising clock edge. A read of the address written at the same edge returns the contents held before that write.
- R4: With `rate_scale` at or above 0x8000 (1.0 in unsigned Q1.15) and the mute level full, the stored sample equals the input sample exactly.
- R5: With `rate_scale` below 0x8000, the stored sample is floor(sample × rate_scale / 32768), using the signed two's-complement value of the sample.
- R6: While `mute_req` is 1, each accepted pair lowers the mute level by one until it reaches 0. The stored value is floor(floor(sample × r / 32768) × (level × 32) / 32768), where r is the effective rate factor and level is the value before that pair's step.
- R7: While `mute_req` is 0, each accepted pair raises the mute level by one until it reaches the full level of 1024, after which the gain is exactly 1.0.
- R8: Cycles without `in_valid` write nothing, and leave both the write counter and the mute level unchanged.
- R9: Left and right samples of one pair are scaled by the same gain and written to the same address, each into its own channel memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: a new input pair is present |
| in_left | input | 24 | Left input sample, signed two's complement |
| in_right | input | 24 | Right input sample, signed two's complement |
| mute_req | input | 1 | 1 requests a soft mute, 0 requests unmute |
| rate_scale | input | 16 | Rate attenuation, unsigned Q1.15; 0x8000 or more means no attenuation |
| rd_addr | input | 9 | Read address from the convolution engine |
| rd_left | output | 24 | Left channel data at the previous cycle's read address |
| rd_right | output | 24 | Right channel data at the previous cycle's read address |

## Verification
The assertions assume that `mute_req` and `rate_scale` hold valid, known values whenever `in_valid` is high. They also assume that reset is applied before the first strobe, so the ramp level and the write counter start from the states that R1 defines. The stimulus changes every input only at the falling clock edge. It toggles `mute_req` at arbitrary points, including in the middle of a ramp and right at its ends, so every transition of the ramp machine is taken. Reads are aimed at the last address written, at the address being written in that same cycle, and at random addresses. The reference model compares only those reads whose target address has already been written since reset.

// File: rtl/sgf_pkg.sv
package sgf_pkg;

    // Mute ramp states
    typedef enum logic [1:0] {
        ST_OPEN     = 2'd0,
        ST_FADE_OUT = 2'd1,
        ST_SILENT   = 2'd2,
        ST_FADE_IN  = 2'd3
    } ramp_state_e;

    localparam int CHANNELS = 2;
    localparam int CH_LEFT  = 0;
    localparam int CH_RIGHT = 1;

endpackage

// File: rtl/sgf_gain_ramp.sv
module sgf_gain_ramp
    import sgf_pkg::*;
#(
    parameter int GAIN_W   = 16,
    parameter int RAMP_LEN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              mute,
    output logic [GAIN_W-1:0] gain
);
    localparam int FRAC  = GAIN_W - 1;
    localparam int LVL_W = $clog2(RAMP_LEN + 1);
    localparam int MUL_W = LVL_W + GAIN_W;
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(RAMP_LEN);
    localparam logic [LVL_W-1:0] LVL_TOP1 = LVL_W'(RAMP_LEN - 1);
    localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);

    ramp_state_e      state, state_nx;
    logic [LVL_W-1:0] lvl, lvl_nx;
    logic [MUL_W-1:0] scaled;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OPEN;
            lvl   <= LVL_FULL;
        end else if (step) begin
            state <= state_nx;
            lvl   <= lvl_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        lvl_nx   = lvl;
        unique case (state)
            ST_OPEN: begin
                if (mute) begin
                    state_nx = ST_FADE_OUT;
                    lvl_nx   = lvl - LVL_ONE;
                end
            end
            ST_FADE_OUT: begin
                if (!mute) begin
                    state_nx = (lvl == LVL_TOP1) ? ST_OPEN : ST_FADE_IN;
                    lvl_nx   = lvl + LVL_ONE;
                end else begin
                    lvl_nx = lvl - LVL_ONE;
                    if (lvl == LVL_ONE) state_nx = ST_SILENT;
                end
            end
            ST_SILENT: begin
                if (!mute) begin
                    state_nx = ST_FADE_IN;
                    lvl_nx   = lvl + LVL_ONE;
                end
            end
            ST_FADE_IN: begin
                if (mute) begin
                    state_nx = (lvl == LVL_ONE) ? ST_SILENT : ST_FADE_OUT;
                    lvl_nx   = lvl - LVL_ONE;
                end else begin
                    lvl_nx = lvl + LVL_ONE;
                    if (lvl == LVL_TOP1) state_nx = ST_OPEN;
                end
            end
        endcase
    end

    // Output: level mapped to unsigned Q1.15 gain
    always_comb begin
        scaled = (MUL_W'(lvl) << FRAC) / MUL_W'(RAMP_LEN);
        gain   = GAIN_W'(scaled);
    end

    AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= LVL_FULL); // R6
    AST_LVL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mute && lvl != '0) |=> lvl == $past(lvl) - LVL_ONE); // R6
    AST_LVL_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !mute && lvl != LVL_FULL) |=> lvl == $past(lvl) + LVL_ONE); // R7
    AST_SILENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SILENT |-> lvl == '0); // R6
    AST_OPEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_OPEN |-> lvl == LVL_FULL); // R7
    AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(lvl) && $stable(state)); // R8

endmodule

// File: rtl/sgf_scaler.sv
module sgf_scaler #(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 16
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [GAIN_W-1:0] rate_fac,
    input  logic [GAIN_W-1:0] mute_fac,
    output logic [DATA_W-1:0] scaled
);
    localparam int FRAC = GAIN_W - 1;
    localparam int PW   = DATA_W + GAIN_W + 1;
    localparam logic [GAIN_W-1:0] ONE = GAIN_W'(1) << FRAC;

    logic [GAIN_W-1:0]        rate_eff;
    logic signed [PW-1:0]     s_ext, r_ext, m_ext, p1, p2;
    logic signed [DATA_W-1:0] stage1;

    always_comb begin
        rate_eff = (rate_fac >= ONE) ? ONE : rate_fac;
        s_ext    = PW'($signed(sample));
        r_ext    = PW'($signed({1'b0, rate_eff}));
        m_ext    = PW'($signed({1'b0, mute_fac}));
        p1       = s_ext * r_ext;
        stage1   = DATA_W'(p1 >>> FRAC);
        p2       = PW'(stage1) * m_ext;
        scaled   = DATA_W'(p2 >>> FRAC);
    end

endmodule

// File: rtl/sgf_wr_ptr.sv
module sgf_wr_ptr #(
    parameter int DEPTH = 512,
    parameter int GUARD = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    output logic [$clog2(DEPTH)-1:0] waddr
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (step) cnt <= cnt + AW'(1);
    end

    assign waddr = cnt + AW'(GUARD);

    AST_WADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> waddr == $past(waddr) + AW'(1)); // R2
    AST_WADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(waddr)); // R8

endmodule

// File: rtl/sgf_chan_ram.sv
module sgf_chan_ram #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read, returns contents before a same-edge write
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end

endmodule

// File: rtl/stereo_gain_fifo.sv
module stereo_gain_fifo
    import sgf_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int GAIN_W   = 16,
    parameter int DEPTH    = 512,
    parameter int GUARD    = 16,
    parameter int RAMP_LEN = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_left,
    input  logic [DATA_W-1:0]        in_right,
    input  logic                     mute_req,
    input  logic [GAIN_W-1:0]        rate_scale,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_left,
    output logic [DATA_W-1:0]        rd_right
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [GAIN_W-1:0] ONE = GAIN_W'(1) << (GAIN_W - 1);

    logic [GAIN_W-1:0] mute_gain;
    logic [AW-1:0]     waddr;
    logic [DATA_W-1:0] ch_in  [CHANNELS];
    logic [DATA_W-1:0] ch_wr  [CHANNELS];
    logic [DATA_W-1:0] ch_rd  [CHANNELS];

    assign ch_in[CH_LEFT]  = in_left;
    assign ch_in[CH_RIGHT] = in_right;

    sgf_gain_ramp #(.GAIN_W(GAIN_W), .RAMP_LEN(RAMP_LEN)) u_ramp (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .mute(mute_req), .gain(mute_gain)
    );

    sgf_wr_ptr #(.DEPTH(DEPTH), .GUARD(GUARD)) u_wptr (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .waddr(waddr)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        sgf_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
            .sample(ch_in[c]), .rate_fac(rate_scale), .mute_fac(mute_gain),
            .scaled(ch_wr[c])
        );
        sgf_chan_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
            .clk(clk), .rst_n(rst_n), .we(in_valid), .waddr(waddr),
            .wdata(ch_wr[c]), .raddr(rd_addr), .rdata(ch_rd[c])
        );
    end

    assign rd_left  = ch_rd[CH_LEFT];
    assign rd_right = ch_rd[CH_RIGHT];

    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rate_scale >= ONE && mute_gain == ONE)
            |-> (ch_wr[CH_LEFT] == in_left && ch_wr[CH_RIGHT] == in_right)); // R4
    AST_SILENT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute_gain == '0)
            |-> (ch_wr[CH_LEFT] == '0 && ch_wr[CH_RIGHT] == '0)); // R6
    AST_SAME_LR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_left == in_right) |-> ch_wr[CH_LEFT] == ch_wr[CH_RIGHT]); // R9

endmodule

// File: tb/stereo_gain_fifo_tb_top.sv
module stereo_gain_fifo_tb_top;
    localparam int DW = 24;
    localparam int DEPTH = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_left = '0, in_right = '0;
    logic mute_req = 1'b0;
    logic [15:0] rate_scale = 16'h8000;
    logic [8:0] rd_addr = '0;
    logic [DW-1:0] rd_left, rd_right;

    always #5 clk = ~clk;

    stereo_gain_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .mute_req(mute_req), .rate_scale(rate_scale),
        .rd_addr(rd_addr), .rd_left(rd_left), .rd_right(rd_right)
    );

    // Behavioural reference state
    longint m_l [DEPTH];
    longint m_r [DEPTH];
    bit     m_ok [DEPTH];
    int     m_cnt = 0;
    int     m_lvl = 1024;
    longint e_l = 0, e_r = 0;
    bit     e_ok = 1'b0;
    int     n_chk = 0, n_bad = 0;
    string  tag = "R1";

    function automatic longint sx(logic [DW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint scale(longint s, int r, int lv);
        longint rr, g, a;
        rr = (r >= 32768) ? 32768 : r;
        g  = (longint'(lv) * 32768) / 1024;
        a  = (s * rr) >>> 15;
        return (a * g) >>> 15;
    endfunction

    task automatic check(string req, longint got, longint exp, string what);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // One clock: model follows the edge, then compare at the falling edge
    task automatic step();
        int wa;
        @(posedge clk);
        e_ok = m_ok[rd_addr];
        e_l  = m_l[rd_addr];
        e_r  = m_r[rd_addr];
        if (in_valid) begin
            wa = (m_cnt + 16) % DEPTH;
            m_l[wa] = scale(sx(in_left), int'(rate_scale), m_lvl);
            m_r[wa] = scale(sx(in_right), int'(rate_scale), m_lvl);
            m_ok[wa] = 1'b1;
            m_cnt++;
            if (mute_req && m_lvl > 0) m_lvl--;
            else if (!mute_req && m_lvl < 1024) m_lvl++;
        end
        @(negedge clk);
        if (e_ok) begin
            check(tag, sx(rd_left), e_l, "left");
            check(tag, sx(rd_right), e_r, "right");
        end
    endtask

    function automatic logic [DW-1:0] rnd_sample();
        int k;
        k = $urandom_range(0, 15);
        if (k == 0) return 24'h800000;
        if (k == 1) return 24'h7FFFFF;
        return DW'($urandom);
    endfunction

    // Drive one cycle; rmode 0: last written, 1: being written now, 2: random
    task automatic drive(bit v, int rmode);
        in_valid = v;
        in_left  = rnd_sample();
        in_right = rnd_sample();
        case (rmode)
            0: rd_addr = 9'((m_cnt + 15) % DEPTH);
            1: rd_addr = 9'((m_cnt + 16) % DEPTH);
            default: rd_addr = 9'($urandom);
        endcase
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset outputs
        check("R1", sx(rd_left), 0, "rd_left after reset");
        check("R1", sx(rd_right), 0, "rd_right after reset");

        // R2 / R3: first pair at address 16, visible one clock after read
        tag = "R2";
        in_valid = 1'b1; in_left = 24'h123456; in_right = 24'hFEDCBA; rd_addr = 9'd16;
        step();
        in_valid = 1'b0; rd_addr = 9'd16;
        step();
        check("R2", sx(rd_left), 64'h123456, "first pair at 16 left");
        check("R3", sx(rd_right), sx(24'hFEDCBA), "first pair at 16 right");

        // R4: bypass at unity and above, reads incl. same-cycle collision (R3)
        tag = "R4";
        for (int i = 0; i < 600; i++) begin
            rate_scale = (i % 2 == 0) ? 16'h8000 : 16'hFFFF;
            drive(1'b1, i % 3);
        end

        // R5: attenuation for decimation
        tag = "R5";
        for (int i = 0; i < 300; i++) begin
            rate_scale = (i < 100) ? 16'h4000 : (i < 200) ? 16'h1234 : 16'h7FFF;
            drive(1'b1, i % 3);
        end

        // R8: gaps without strobe keep pointer and ramp
        tag = "R8";
        for (int i = 0; i < 200; i++) begin
            rate_scale = 16'h6000;
            mute_req = (i % 7 == 0);
            drive((i % 3) == 0, (i % 2 == 0) ? 0 : 2);
        end
        mute_req = 1'b0;
        for (int i = 0; i < 20; i++) drive(1'b1, 0);

        // R6: full fade-out to silence, with a reversal mid-ramp
        tag = "R6";
        rate_scale = 16'h8000;
        mute_req = 1'b1;
        for (int i = 0; i < 300; i++) drive(1'b1, i % 3);
        mute_req = 1'b0;
        for (int i = 0; i < 50; i++) drive(1'b1, 0);
        mute_req = 1'b1;
        for (int i = 0; i < 1100; i++) drive(1'b1, (i % 5 == 0) ? 2 : 0);
        check("R6", longint'(m_lvl), 0, "model level at silence");

        // R7: fade back in, reversal right at the bottom, then to full
        tag = "R7";
        mute_req = 1'b0;
        drive(1'b1, 0);
        mute_req = 1'b1;
        drive(1'b1, 0);
        mute_req = 1'b0;
        for (int i = 0; i < 1030; i++) drive(1'b1, (i % 4 == 0) ? 1 : 0);
        mute_req = 1'b1;
        drive(1'b1, 0);
        mute_req = 1'b0;
        for (int i = 0; i < 20; i++) drive(1'b1, 0);

        // R9: identical and differing L/R under mixed gain
        tag = "R9";
        mute_req = 1'b1;
        rate_scale = 16'h2ABC;
        for (int i = 0; i < 200; i++) begin
            in_valid = 1'b1;
            in_left = rnd_sample();
            in_right = (i % 2 == 0) ? in_left : rnd_sample();
            rd_addr = 9'((m_cnt + 15) % DEPTH);
            step();
        end
        in_valid = 1'b0;
        step();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule